// File: doc/BRIEF.md
# Bus-Attached Serial Port with One-Shot Transmit

This block hangs a full-duplex asynchronous serial port off a processor's data-memory bus. Two word addresses are decoded: a data location, where a store queues one byte for transmission and a load returns the most recently received byte, and a status location that reports whether the transmitter can take a byte and whether a received byte is waiting. Both directions use frames of one start bit, eight data bits and one stop bit, with no parity bit, at 28800 baud from a 100 MHz clock.

A pipelined processor can hold a store on the bus for several cycles while it is stalled. The transmitter therefore reacts only to the first cycle of a write request. The request must drop for at least one cycle before another byte can be accepted, so a stalled store sends one byte and never two. The receiver passes the serial input through a two-stage synchronizer and times it with a tick at sixteen times the bit rate. It confirms a start bit at half a bit period and samples each later bit at its centre.

Top module: `mmio_uart`

## Requirements
- R1: A write to address 0x00010000 while tx_ready is high sends bus_wdata on tx_o. The frame is a low start bit, then eight data bits with the least significant bit first, then a high stop bit. Each bit lasts 16 ticks of TICK_DIV clocks, and the line is high whenever tx_ready is high.
- R2: tx_ready is low from the clock edge that accepts a write. It returns high exactly 160 × TICK_DIV clock cycles later, at the end of the stop bit.
- R3: A write to the data address while tx_ready is low is ignored. It produces no frame, either then or later.
- R4: A write request held for several consecutive cycles produces one frame only, even if it is still held after that frame ends. Another byte is accepted only after the request has been absent for at least one cycle.
- R5: A read (bus_re high) of address 0x00010004 returns tx_ready in bit 0 and rx_ready in bit 1, with bits 31:2 zero. Reads of other addresses, and bus_rdata when bus_re is low, are zero. Writes to the status address have no effect.
- R6: The receiver synchronizes rx_i through two flip-flops and samples each data bit at its centre, least significant bit first. When it samples a high stop bit, it stores the byte, which a read of 0x00010000 returns in bits 7:0, and it sets rx_ready.
- R7: A read of address 0x00010000 clears rx_ready.
- R8: A low pulse on rx_i that is high again at the half-bit check is treated as a glitch. It delivers no byte and leaves rx_ready and the stored byte unchanged.
- R9: A frame whose stop bit is sampled low is discarded. rx_ready and the stored byte stay unchanged.
- R10: After reset, tx_o is high, tx_ready is 1, rx_ready is 0 and the stored received byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the bus access |
| bus_we | input | 1 | Write request, may be held across stall cycles |
| bus_re | input | 1 | Read request |
| bus_wdata | input | 8 | Low byte of the store data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| tx_o | output | 1 | Serial output, idle high |

## Verification
The assertions assume that reset is applied from time zero and that the bus inputs are stable around each rising edge. The one-shot and frame-length properties assume that no write reaches the data address during reset. The bench changes every bus signal and the serial input only on falling edges, and it holds reset over the first clock edges. It drives received frames at the configured bit period with transitions only on bit boundaries, so the centre samples of the receiver never fall on an edge. It never starts a received frame in the same cycle as a data read, so a read and a completing frame do not meet on rx_ready.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;

    localparam logic [31:0] ADDR_DATA = 32'h0001_0000;
    localparam logic [31:0] ADDR_STAT = 32'h0001_0004;
    localparam int          DATA_BITS = 8;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic hit_data;
        logic hit_stat;
    } addr_dec_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } rx_byte_t;

    function automatic addr_dec_t decode_addr(input logic [31:0] a);
        addr_dec_t d;
        d.hit_data = (a == ADDR_DATA);
        d.hit_stat = (a == ADDR_STAT);
        return d;
    endfunction

    function automatic int tick_divisor(input int clk_hz, input int baud, input int os);
        return (clk_hz + (baud * os) / 2) / (baud * os);
    endfunction

endpackage

// File: rtl/uart_mm_tick.sv
module uart_mm_tick #(
    parameter int DIV = 217
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST) && !restart;

endmodule

// File: rtl/uart_mm_tx.sv
module uart_mm_tx
    import uart_mm_pkg::*;
#(
    parameter int TICK_DIV   = 217,
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] din,
    output logic       line_o,
    output logic       ready
);
    localparam int TW = $clog2(OVERSAMPLE);
    localparam logic [TW-1:0] T_LAST = TW'(OVERSAMPLE - 1);

    tx_state_e     state;
    logic [7:0]    shreg;
    logic [TW-1:0] tcnt;
    logic [2:0]    bidx;
    logic          tick;
    logic          accept;

    assign accept = go && (state == TX_IDLE);
    assign ready  = (state == TX_IDLE);

    uart_mm_tick #(.DIV(TICK_DIV)) tick_i (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            shreg  <= '0;
            tcnt   <= '0;
            bidx   <= '0;
            line_o <= 1'b1;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (accept) begin
                        state  <= TX_START;
                        shreg  <= din;
                        tcnt   <= '0;
                        line_o <= 1'b0;
                    end
                end
                TX_START: begin
                    if (tick) begin
                        if (tcnt == T_LAST) begin
                            tcnt   <= '0;
                            bidx   <= '0;
                            state  <= TX_DATA;
                            line_o <= shreg[0];
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        if (tcnt == T_LAST) begin
                            tcnt <= '0;
                            if (bidx == 3'(DATA_BITS - 1)) begin
                                state  <= TX_STOP;
                                line_o <= 1'b1;
                            end else begin
                                bidx   <= bidx + 1'b1;
                                shreg  <= {1'b0, shreg[7:1]};
                                line_o <= shreg[1];
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                TX_STOP: begin
                    if (tick) begin
                        if (tcnt == T_LAST) begin
                            tcnt  <= '0;
                            state <= TX_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_mm_rx.sv
module uart_mm_rx
    import uart_mm_pkg::*;
#(
    parameter int TICK_DIV   = 217,
    parameter int OVERSAMPLE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    output rx_byte_t result
);
    localparam int TW = $clog2(OVERSAMPLE);
    localparam logic [TW-1:0] T_LAST = TW'(OVERSAMPLE - 1);
    localparam logic [TW-1:0] T_HALF = TW'(OVERSAMPLE / 2 - 1);

    rx_state_e     state;
    logic          sync1;
    logic          sync2;
    logic [7:0]    shreg;
    logic [TW-1:0] tcnt;
    logic [2:0]    bidx;
    logic          tick;
    logic          begin_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= line_i;
            sync2 <= sync1;
        end
    end

    assign begin_frame = (state == RX_IDLE) && !sync2;

    uart_mm_tick #(.DIV(TICK_DIV)) tick_i (
        .clk     (clk),
        .rst     (rst),
        .restart (begin_frame),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            shreg  <= '0;
            tcnt   <= '0;
            bidx   <= '0;
            result <= '0;
        end else begin
            result.valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (begin_frame) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tcnt == T_HALF) begin
                            tcnt <= '0;
                            bidx <= '0;
                            state <= sync2 ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (tcnt == T_LAST) begin
                            tcnt  <= '0;
                            shreg <= {sync2, shreg[7:1]};
                            if (bidx == 3'(DATA_BITS - 1)) begin
                                state <= RX_STOP;
                            end else begin
                                bidx <= bidx + 1'b1;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (tcnt == T_LAST) begin
                            tcnt         <= '0;
                            state        <= RX_IDLE;
                            result.valid <= sync2;
                            result.data  <= shreg;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
    import uart_mm_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int BAUD       = 28_800,
    parameter int OVERSAMPLE = 16,
    parameter int TICK_DIV   = tick_divisor(CLK_HZ, BAUD, OVERSAMPLE)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] bus_addr,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [7:0]  bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_i,
    output logic        tx_o
);
    addr_dec_t dec;
    logic      wr_hit;
    logic      wr_hit_q;
    logic      tx_go;
    logic      tx_ready;
    logic      rd_clear;
    logic      rx_ready;
    logic [7:0] rx_data;
    rx_byte_t  rx_res;

    assign dec      = decode_addr(bus_addr);
    assign wr_hit   = bus_we && dec.hit_data;
    assign rd_clear = bus_re && dec.hit_data;
    assign tx_go    = wr_hit && !wr_hit_q && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_hit_q <= 1'b0;
        end else begin
            wr_hit_q <= wr_hit;
        end
    end

    uart_mm_tx #(
        .TICK_DIV   (TICK_DIV),
        .OVERSAMPLE (OVERSAMPLE)
    ) tx_i (
        .clk    (clk),
        .rst    (rst),
        .go     (tx_go),
        .din    (bus_wdata),
        .line_o (tx_o),
        .ready  (tx_ready)
    );

    uart_mm_rx #(
        .TICK_DIV   (TICK_DIV),
        .OVERSAMPLE (OVERSAMPLE)
    ) rx_i_u (
        .clk    (clk),
        .rst    (rst),
        .line_i (rx_i),
        .result (rx_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_ready <= 1'b0;
            rx_data  <= '0;
        end else if (rx_res.valid) begin
            rx_ready <= 1'b1;
            rx_data  <= rx_res.data;
        end else if (rd_clear) begin
            rx_ready <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (dec.hit_data) begin
                bus_rdata = {24'h0, rx_data};
            end else if (dec.hit_stat) begin
                bus_rdata = {30'h0, rx_ready, tx_ready};
            end
        end
    end

endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk
    import uart_mm_pkg::*;
#(
    parameter int TICK_DIV   = 217,
    parameter int OVERSAMPLE = 16
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] bus_addr,
    input logic        bus_we,
    input logic        bus_re,
    input logic [31:0] bus_rdata,
    input logic        tx_o,
    input logic        tx_ready
);
    localparam int FRAME_CYCLES = (DATA_BITS + 2) * OVERSAMPLE * TICK_DIV;

    int   busy_cnt;
    logic req_now;
    logic req_prev;

    assign req_now = bus_we && (bus_addr == ADDR_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_cnt <= 0;
            req_prev <= 1'b0;
        end else begin
            busy_cnt <= tx_ready ? 0 : busy_cnt + 1;
            req_prev <= req_now;
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> tx_o); // R1

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_ready) |-> !tx_o); // R1

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_ready) |-> (busy_cnt == FRAME_CYCLES)); // R2

    AST_HELD_WRITE_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && req_now && req_prev) |=> tx_ready); // R4

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == ADDR_STAT) |-> (bus_rdata[31:2] == 30'h0)); // R5

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_re |-> (bus_rdata == 32'h0)); // R5

endmodule

bind mmio_uart mmio_uart_chk #(
    .TICK_DIV   (TICK_DIV),
    .OVERSAMPLE (OVERSAMPLE)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .tx_o      (tx_o),
    .tx_ready  (tx_ready)
);

// File: tb/mmio_uart_tb.sv
`timescale 1ns/1ps
module mmio_uart_tb_top;
    localparam int DIV   = 8;
    localparam int BITC  = 16 * DIV;
    localparam int FRAME = 10 * BITC;
    localparam logic [31:0] A_DATA = 32'h0001_0000;
    localparam logic [31:0] A_STAT = 32'h0001_0004;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_i = 1'b1;
    logic        tx_o;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    mmio_uart #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_i(rx_i), .tx_o(tx_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [7:0] d, input int hold);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        repeat (hold) @(negedge clk);
        bus_we = 1'b0; bus_addr = '0;
    endtask

    task automatic send_byte(input logic [7:0] d, input int hold);
        exp_q.push_back(d);
        bus_write(A_DATA, d, hold);
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0; bus_addr = '0;
    endtask

    task automatic drive_frame(input logic [7:0] d, input int stop_low_ticks);
        @(negedge clk);
        rx_i = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_i = d[i];
            repeat (BITC) @(negedge clk);
        end
        if (stop_low_ticks > 0) begin
            rx_i = 1'b0;
            repeat (stop_low_ticks * DIV) @(negedge clk);
        end
        rx_i = 1'b1;
        repeat (2 * BITC) @(negedge clk);
    endtask

    // Scoreboard monitor: decodes tx_o and compares against the queue
    initial begin
        logic [7:0] got;
        logic [7:0] want;
        forever begin
            @(negedge clk);
            if (!rst && tx_o == 1'b0) begin
                repeat (8 * DIV) @(negedge clk);
                chk(tx_o == 1'b0, "R1 start bit", {31'h0, tx_o}, 32'h0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    got[i] = tx_o;
                end
                repeat (BITC) @(negedge clk);
                chk(tx_o == 1'b1, "R1 stop bit", {31'h0, tx_o}, 32'h1);
                frames_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R4 unexpected frame", {24'h0, got}, 32'h0);
                end else begin
                    want = exp_q.pop_front();
                    chk(got == want, "R1 tx byte", {24'h0, got}, {24'h0, want});
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        int f0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk(tx_o == 1'b1, "R10 tx idle", {31'h0, tx_o}, 32'h1);
        bus_read(A_STAT, v);
        chk(v == 32'h1, "R10 status", v, 32'h1);
        bus_read(A_DATA, v);
        chk(v == 32'h0, "R10 rx data", v, 32'h0);

        // R1 basic transmit
        send_byte(8'hA5, 1);
        repeat (FRAME + 40) @(negedge clk);

        // R2 busy window length, observed on status bit 0
        @(negedge clk);
        bus_addr = A_DATA; bus_wdata = 8'h3C; bus_we = 1'b1;
        exp_q.push_back(8'h3C);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = A_STAT; bus_re = 1'b1;
        #1;
        chk(bus_rdata[0] == 1'b0, "R2 ready low after write", bus_rdata, 32'h0);
        n = 0;
        while (bus_rdata[0] != 1'b1 && n < 2 * FRAME) begin
            @(negedge clk);
            #1;
            n++;
        end
        bus_re = 1'b0; bus_addr = '0;
        chk(n == FRAME, "R2 busy cycles", n, FRAME);
        repeat (40) @(negedge clk);

        // R4 stalled store held briefly, then held past the frame end
        f0 = frames_seen;
        send_byte(8'h5A, 6);
        repeat (FRAME + 40) @(negedge clk);
        send_byte(8'h81, FRAME + 60);
        repeat (FRAME + 40) @(negedge clk);
        chk(frames_seen == f0 + 2, "R4 one frame per held store", frames_seen - f0, 2);

        // R3 write while busy ignored
        f0 = frames_seen;
        send_byte(8'h11, 1);
        repeat (20) @(negedge clk);
        bus_write(A_DATA, 8'h22, 1);
        repeat (2 * FRAME + 40) @(negedge clk);
        chk(frames_seen == f0 + 1, "R3 busy write dropped", frames_seen - f0, 1);

        // R5 status write no effect, unmapped read zero
        f0 = frames_seen;
        bus_write(A_STAT, 8'hFF, 1);
        repeat (FRAME) @(negedge clk);
        chk(frames_seen == f0, "R5 status write no frame", frames_seen - f0, 0);
        bus_read(32'h0001_0008, v);
        chk(v == 32'h0, "R5 unmapped read", v, 32'h0);

        // R6 receive, R7 clear on read
        drive_frame(8'h96, 0);
        bus_read(A_STAT, v);
        chk(v == 32'h3, "R6 rx_ready set", v, 32'h3);
        bus_read(A_DATA, v);
        chk(v == 32'h96, "R6 rx byte", v, 32'h96);
        bus_read(A_STAT, v);
        chk(v[1] == 1'b0, "R7 rx_ready cleared", v, 32'h1);

        // R8 glitch on the line
        @(negedge clk);
        rx_i = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        rx_i = 1'b1;
        repeat (2 * BITC) @(negedge clk);
        bus_read(A_STAT, v);
        chk(v[1] == 1'b0, "R8 glitch no byte", v, 32'h1);
        bus_read(A_DATA, v);
        chk(v == 32'h96, "R8 data kept", v, 32'h96);

        // R9 low stop bit discards frame
        drive_frame(8'h3E, 10);
        bus_read(A_STAT, v);
        chk(v[1] == 1'b0, "R9 bad stop no ready", v, 32'h1);
        bus_read(A_DATA, v);
        chk(v == 32'h96, "R9 data kept", v, 32'h96);

        // R6 and R1 together: full duplex
        fork
            send_byte(8'h7E, 1);
            drive_frame(8'h42, 0);
        join
        repeat (FRAME) @(negedge clk);
        bus_read(A_STAT, v);
        chk(v == 32'h3, "R6 duplex status", v, 32'h3);
        bus_read(A_DATA, v);
        chk(v == 32'h42, "R6 duplex byte", v, 32'h42);

        chk(exp_q.size() == 0, "R1 all bytes sent", exp_q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule